// File: doc/BRIEF.md
# Keyboard-Steered Bouncing Ball Controller

This block keeps the position and motion of one ball on a 640x480 raster. Once per frame a strobe advances the ball by a fixed step along its current motion vector. The most recent keyboard usage code is sampled on that strobe. A direction key replaces the motion vector with a single-axis vector. A released key (code 0x00) or any non-direction code leaves the vector as it is.

When the ball's boundary, which is the centre plus or minus the radius, touches a screen edge on the axis of motion, the velocity on that axis is negated. The step of that same frame then carries the ball away from the edge. Once the ball is moving, it never stops and never travels diagonally. Any sequence of keys is accepted without a reset.

A combinational output reports whether the raster coordinate currently being drawn lies inside the ball disc. A colour stage can use it directly.

Top module: `ball_steer`

## Requirements
- R1: While `rst` is high at a clock edge, the ball is set to the centre (X=320, Y=240) with both velocity components 0. It then stays there until a direction key is seen on a frame strobe.
- R2: Position and velocity change only on a clock edge where `frame_tick` is high. On any other edge, including when a direction key is present on `key_code`, they hold.
- R3: On a strobe, key code 0x1A selects up (vy=-1), 0x16 selects down (vy=+1), 0x04 selects left (vx=-1) and 0x07 selects right (vx=+1). The new vector moves the ball in that same update, starting from its current position.
- R4: On a strobe, key code 0x00 or any code other than the four direction codes leaves the velocity unchanged. A stationary ball therefore stays put.
- R5: At most one velocity component is nonzero at any time. Selecting a direction clears the component on the other axis.
- R6: If the ball moves right with X >= 635 (X+radius reaches 639), or moves down with Y >= 475 (Y+radius reaches 479), the strobe negates that component, and the ball moves one pixel back. This also applies when the direction key pointing into that edge is pressed on the strobe.
- R7: If the ball moves left with X <= 4, or moves up with Y <= 4, the strobe negates that component, and the ball moves one pixel back. Y grows downward, so row 0 is the top.
- R8: Once a velocity component is nonzero, a strobe never returns both components to zero.
- R9: The centre stays within X in [4, 635] and Y in [4, 475] with the default radius of 4.
- R10: `in_ball` is high exactly when (pix_x-X)^2 + (pix_y-Y)^2 <= radius^2. It is combinational in the pixel inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle strobe per frame that advances the ball |
| key_code | input | 8 | Most recent keyboard usage code, 0x00 when no key is held |
| pix_x | input | 10 | Raster column under test |
| pix_y | input | 9 | Raster row under test |
| ball_x | output | 10 | Ball centre column |
| ball_y | output | 9 | Ball centre row |
| vel_x | output | 4 | Signed horizontal velocity |
| vel_y | output | 4 | Signed vertical velocity |
| in_ball | output | 1 | Raster coordinate lies inside the ball |

## Verification
A key decode and an edge reflection can act on the same strobe. This happens when the ball sits on an edge and the key pointing into that edge is pressed. The bench drives the ball to X=635 and then presses the right-arrow code on successive strobes. The ball must alternate between 635 and 634, with the velocity flipping to -1 each time it starts from the edge, and it must never go beyond the edge. Reflection alone is judged separately at all four edges, at the exact strobe count computed from the starting position.

// File: rtl/ball_steer.sv
module ball_steer #(
  parameter int H_RES  = 640,
  parameter int V_RES  = 480,
  parameter int RADIUS = 4,
  parameter int STEP   = 1,
  parameter int VW     = 4,
  parameter logic [7:0] KEY_UP    = 8'h1A,
  parameter logic [7:0] KEY_DOWN  = 8'h16,
  parameter logic [7:0] KEY_LEFT  = 8'h04,
  parameter logic [7:0] KEY_RIGHT = 8'h07,
  localparam int XW = $clog2(H_RES),
  localparam int YW = $clog2(V_RES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_tick,
  input  logic [7:0]           key_code,
  input  logic [XW-1:0]        pix_x,
  input  logic [YW-1:0]        pix_y,
  output logic [XW-1:0]        ball_x,
  output logic [YW-1:0]        ball_y,
  output logic signed [VW-1:0] vel_x,
  output logic signed [VW-1:0] vel_y,
  output logic                 in_ball
);

  localparam logic [XW-1:0] X_MIN = XW'(RADIUS);
  localparam logic [XW-1:0] X_MAX = XW'(H_RES - 1 - RADIUS);
  localparam logic [YW-1:0] Y_MIN = YW'(RADIUS);
  localparam logic [YW-1:0] Y_MAX = YW'(V_RES - 1 - RADIUS);
  localparam logic [XW-1:0] X_MID = XW'(H_RES / 2);
  localparam logic [YW-1:0] Y_MID = YW'(V_RES / 2);
  localparam logic signed [VW-1:0] V_POS = VW'(STEP);
  localparam logic signed [VW-1:0] V_NEG = -VW'(STEP);
  localparam logic [2*XW+1:0] R_SQ = (2*XW+2)'(RADIUS * RADIUS);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic signed [VW-1:0] vx_q, vy_q, vx_sel, vy_sel, vx_nx, vy_nx;
  logic signed [XW+1:0] x_sum;
  logic signed [YW+1:0] y_sum;

  always_comb begin
    vx_sel = vx_q;
    vy_sel = vy_q;
    case (key_code)
      KEY_UP:    begin vx_sel = '0;    vy_sel = V_NEG; end
      KEY_DOWN:  begin vx_sel = '0;    vy_sel = V_POS; end
      KEY_LEFT:  begin vx_sel = V_NEG; vy_sel = '0;    end
      KEY_RIGHT: begin vx_sel = V_POS; vy_sel = '0;    end
      default: ;
    endcase
  end

  assign vx_nx = (vx_sel > 0 && x_q >= X_MAX) ? V_NEG :
                 (vx_sel < 0 && x_q <= X_MIN) ? V_POS : vx_sel;
  assign vy_nx = (vy_sel > 0 && y_q >= Y_MAX) ? V_NEG :
                 (vy_sel < 0 && y_q <= Y_MIN) ? V_POS : vy_sel;

  assign x_sum = $signed({2'b00, x_q}) + (XW+2)'(vx_nx);
  assign y_sum = $signed({2'b00, y_q}) + (YW+2)'(vy_nx);

  assign x_d = (x_sum < $signed({2'b00, X_MIN})) ? X_MIN :
               (x_sum > $signed({2'b00, X_MAX})) ? X_MAX : x_sum[XW-1:0];
  assign y_d = (y_sum < $signed({2'b00, Y_MIN})) ? Y_MIN :
               (y_sum > $signed({2'b00, Y_MAX})) ? Y_MAX : y_sum[YW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= X_MID;
      y_q  <= Y_MID;
      vx_q <= '0;
      vy_q <= '0;
    end else if (frame_tick) begin
      x_q  <= x_d;
      y_q  <= y_d;
      vx_q <= vx_nx;
      vy_q <= vy_nx;
    end
  end

  assign ball_x = x_q;
  assign ball_y = y_q;
  assign vel_x  = vx_q;
  assign vel_y  = vy_q;

  logic signed [XW:0] dx;
  logic signed [YW:0] dy;
  logic [2*XW+1:0] dx_sq, dy_sq;

  assign dx = $signed({1'b0, pix_x}) - $signed({1'b0, x_q});
  assign dy = $signed({1'b0, pix_y}) - $signed({1'b0, y_q});
  assign dx_sq = dx * dx;
  assign dy_sq = (2*XW+2)'(dy * dy);
  assign in_ball = (dx_sq + dy_sq) <= R_SQ;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(x_q) && $stable(y_q) && $stable(vx_q) && $stable(vy_q));

  p_key_right_r3: assert property (@(posedge clk) disable iff (rst)
    frame_tick && key_code == KEY_RIGHT && x_q < X_MAX |=> vx_q == V_POS && vy_q == 0);

  p_one_axis_r5: assert property (@(posedge clk) disable iff (rst)
    !(vx_q != 0 && vy_q != 0));

  p_reflect_right_r6: assert property (@(posedge clk) disable iff (rst)
    frame_tick && key_code == 8'h00 && vx_q > 0 && x_q >= X_MAX |=> vx_q < 0);

  p_reflect_top_r7: assert property (@(posedge clk) disable iff (rst)
    frame_tick && key_code == 8'h00 && vy_q < 0 && y_q <= Y_MIN |=> vy_q > 0);

  p_keep_moving_r8: assert property (@(posedge clk) disable iff (rst)
    frame_tick && (vx_q != 0 || vy_q != 0) |=> (vx_q != 0 || vy_q != 0));

  p_in_bounds_r9: assert property (@(posedge clk) disable iff (rst)
    x_q >= X_MIN && x_q <= X_MAX && y_q >= Y_MIN && y_q <= Y_MAX);

endmodule

// File: tb/ball_steer_tb_top.sv
module ball_steer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic [9:0] pix_x = '0;
  logic [8:0] pix_y = '0;
  logic [9:0] ball_x;
  logic [8:0] ball_y;
  logic signed [3:0] vel_x, vel_y;
  logic in_ball;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ball_steer dut_i (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .key_code(key_code),
    .pix_x(pix_x), .pix_y(pix_y), .ball_x(ball_x), .ball_y(ball_y),
    .vel_x(vel_x), .vel_y(vel_y), .in_ball(in_ball)
  );

  // key, vx, vy, x, y
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {8'h00, 4'h0, 4'h0, 10'd320, 9'd240},
    {8'h05, 4'h0, 4'h0, 10'd320, 9'd240},
    {8'h07, 4'h1, 4'h0, 10'd321, 9'd240},
    {8'h00, 4'h1, 4'h0, 10'd322, 9'd240},
    {8'h1A, 4'h0, 4'hF, 10'd322, 9'd239},
    {8'h2C, 4'h0, 4'hF, 10'd322, 9'd238},
    {8'h16, 4'h0, 4'h1, 10'd322, 9'd239},
    {8'h04, 4'hF, 4'h0, 10'd321, 9'd239},
    {8'h00, 4'hF, 4'h0, 10'd320, 9'd239},
    {8'h07, 4'h1, 4'h0, 10'd321, 9'd239}
  };

  task automatic expect_state(string req, int ex, int ey, int evx, int evy);
    checks++;
    if (int'(ball_x) != ex || int'(ball_y) != ey || int'(vel_x) != evx || int'(vel_y) != evy) begin
      errors++;
      $display("FAIL %s: got x=%0d y=%0d vx=%0d vy=%0d expected x=%0d y=%0d vx=%0d vy=%0d",
               req, ball_x, ball_y, vel_x, vel_y, ex, ey, evx, evy);
    end
  endtask

  task automatic tick(input logic [7:0] k);
    key_code = k;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    key_code = 8'h00;
  endtask

  task automatic pix_check(int px, int py, logic exp);
    pix_x = 10'(px);
    pix_y = 9'(py);
    #1;
    checks++;
    if (in_ball !== exp) begin
      errors++;
      $display("FAIL R10: pixel (%0d,%0d) got %0b expected %0b", px, py, in_ball, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int stopped;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R1 reset centre", 320, 240, 0, 0);

    pix_check(320, 240, 1'b1);
    pix_check(324, 240, 1'b1);
    pix_check(324, 241, 1'b0);
    pix_check(322, 242, 1'b1);
    pix_check(323, 243, 1'b0);
    pix_check(316, 240, 1'b1);
    pix_check(320, 235, 1'b0);

    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][34:27]);
      expect_state($sformatf("R3/R4/R5 vector %0d", i), int'(VEC[i][18:9]), int'(VEC[i][8:0]),
                   int'($signed(VEC[i][26:23])), int'($signed(VEC[i][22:19])));
    end

    key_code = 8'h04;
    repeat (3) @(negedge clk);
    key_code = 8'h00;
    expect_state("R2 key without strobe ignored", 321, 239, 1, 0);

    stopped = 0;
    for (int i = 0; i < 314; i++) begin
      tick(8'h00);
      if (vel_x == 0 && vel_y == 0) stopped++;
    end
    checks++;
    if (stopped != 0) begin
      errors++;
      $display("FAIL R8: got %0d stationary frames expected 0", stopped);
    end
    expect_state("R9 right limit reached", 635, 239, 1, 0);
    tick(8'h00);
    expect_state("R6 right reflection", 634, 239, -1, 0);
    tick(8'h07);
    expect_state("R3 right key near edge", 635, 239, 1, 0);
    tick(8'h07);
    expect_state("R6 right key at edge reflects", 634, 239, -1, 0);

    tick(8'h04);
    expect_state("R3 left key", 633, 239, -1, 0);
    repeat (629) tick(8'h00);
    expect_state("R9 left limit reached", 4, 239, -1, 0);
    tick(8'h00);
    expect_state("R7 left reflection", 5, 239, 1, 0);

    tick(8'h1A);
    expect_state("R5 up clears x", 5, 238, 0, -1);
    repeat (234) tick(8'h00);
    expect_state("R9 top limit reached", 5, 4, 0, -1);
    tick(8'h00);
    expect_state("R7 top reflection", 5, 5, 0, 1);

    repeat (470) tick(8'h00);
    expect_state("R9 bottom limit reached", 5, 475, 0, 1);
    tick(8'h00);
    expect_state("R6 bottom reflection", 5, 474, 0, -1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_state("R1 reset while moving", 320, 240, 0, 0);
    tick(8'h00);
    expect_state("R4 idle after reset", 320, 240, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule